// File: doc/BRIEF.md
# Port Output Level Checker

This block confirms that each pin of an 8-bit general-purpose I/O port really sits at the level the chip means to drive. Every pin has a direction select and a source select. In latch mode the intended level is the port's output latch bit. In peripheral mode it is the internal control signal that a peripheral drives onto that pin. The raw pin levels first pass through a two-stage synchronizer. When a check is requested, the block compares the synchronized levels with the intended levels. A pin set as input always counts as a match, and so does every pin of a port that is strapped as input-only.

A check is a one-cycle strobe with an operation select. The flag-only operation updates just the summary mismatch flag. The vector operation also loads an 8-bit result in which each 1 marks a faulty pin, so software can scan the bits to find it. The results are registered, and a one-cycle done pulse marks them on the clock after the request.

Top module: `port_level_checker`

## Requirements
- R1: On a check, bit b of the comparison is the exclusive OR of synchronized pin b and its intended level; 1 means mismatch.
- R2: The intended level of a pin is its latch bit when its source select is 0 (latch mode) and its control bit when the select is 1 (peripheral mode).
- R3: A pin whose direction bit is 0 (input) always compares as a match, in either mode.
- R4: While the input-only strap is 1, every bit compares as a match.
- R5: On each accepted check of either operation, the mismatch flag loads the OR of the comparison bits, and it then holds until the next check.
- R6: Operation select 1 loads the result vector; operation select 0 leaves the result vector unchanged.
- R7: The done output is high for exactly the one cycle after each accepted request, and low otherwise.
- R8: Synchronous reset clears the result vector, the mismatch flag and done to 0.
- R9: Pin levels reach the comparison through two flops: a request sampled on the first or second clock edge after a pin change still sees the old level, and one sampled on the third edge sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_level_i | input | 8 | Raw pin levels, asynchronous |
| latch_i | input | 8 | Output latch contents |
| ctrl_out_i | input | 8 | Peripheral control outputs for each pin |
| dir_out_i | input | 8 | Direction for each pin, 1 = output |
| src_ctrl_i | input | 8 | Source for each pin, 1 = peripheral, 0 = latch |
| input_only_i | input | 1 | Port strapped as input-only |
| chk_req_i | input | 1 | One-cycle check request |
| chk_op_i | input | 1 | 0 = flag only, 1 = flag and vector |
| done_o | output | 1 | Result-valid pulse |
| mismatch_o | output | 1 | Summary mismatch flag |
| result_vec_o | output | 8 | Mismatch bits, one for each pin |

## Verification
The assertions watch, on every cycle, the timing of done against the request, the holding of the flag and the vector between checks, the flag's agreement with the comparison it sampled, and the masking for input pins and the input-only strap. Only the bench's scenarios can show that each bit's intended level is taken from the right source. The same holds for the exact XOR values across a sweep of pin patterns and for the synchronizer's edge-accurate latency. These need expected values computed from the stimulus, not relations between signals.

// File: rtl/plc_pkg.sv
package plc_pkg;

  typedef enum logic {
    OP_FLAG   = 1'b0,
    OP_VECTOR = 1'b1
  } chk_op_e;

  // Intended level of one pin: peripheral signal or latch bit.
  function automatic logic intended_level(input logic use_ctrl,
                                          input logic latch_bit,
                                          input logic ctrl_bit);
    return use_ctrl ? ctrl_bit : latch_bit;
  endfunction

  // Mismatch of one pin, masked for input pins and input-only ports.
  function automatic logic bit_miss(input logic pin_bit,
                                    input logic want_bit,
                                    input logic drives,
                                    input logic in_only);
    return (drives & ~in_only) & (pin_bit ^ want_bit);
  endfunction

endpackage

// File: rtl/plc_sync.sv
module plc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)
          stage_q[s] <= '0;
        else if (s == 0)
          stage_q[s] <= async_i;
        else
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/plc_compare.sv
module plc_compare #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] ctrl_i,
  input  logic [WIDTH-1:0] dir_out_i,
  input  logic [WIDTH-1:0] src_ctrl_i,
  input  logic             input_only_i,
  output logic [WIDTH-1:0] miss_o
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic want;
      assign want      = plc_pkg::intended_level(src_ctrl_i[b], latch_i[b], ctrl_i[b]);
      assign miss_o[b] = plc_pkg::bit_miss(pin_i[b], want, dir_out_i[b], input_only_i);
    end
  endgenerate

endmodule

// File: rtl/plc_result.sv
module plc_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept_i,
  input  logic             load_vec_i,
  input  logic [WIDTH-1:0] miss_i,
  output logic             done_o,
  output logic             flag_o,
  output logic [WIDTH-1:0] vec_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      flag_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      done_o <= accept_i;
      if (accept_i)
        flag_o <= |miss_i;
      if (accept_i && load_vec_i)
        vec_o <= miss_i;
    end
  end

endmodule

// File: rtl/port_level_checker.sv
module port_level_checker #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_level_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] ctrl_out_i,
  input  logic [WIDTH-1:0] dir_out_i,
  input  logic [WIDTH-1:0] src_ctrl_i,
  input  logic             input_only_i,
  input  logic             chk_req_i,
  input  logic             chk_op_i,
  output logic             done_o,
  output logic             mismatch_o,
  output logic [WIDTH-1:0] result_vec_o
);

  // Named internal events, visible to the bound checker.
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] cmp_vec;
  logic             chk_accept;
  logic             vec_load;

  assign chk_accept = chk_req_i;
  assign vec_load   = (chk_op_i == plc_pkg::OP_VECTOR);

  plc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (pin_level_i),
    .sync_o  (pin_sync)
  );

  plc_compare #(.WIDTH(WIDTH)) u_cmp (
    .pin_i        (pin_sync),
    .latch_i      (latch_i),
    .ctrl_i       (ctrl_out_i),
    .dir_out_i    (dir_out_i),
    .src_ctrl_i   (src_ctrl_i),
    .input_only_i (input_only_i),
    .miss_o       (cmp_vec)
  );

  plc_result #(.WIDTH(WIDTH)) u_res (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (chk_accept),
    .load_vec_i (vec_load),
    .miss_i     (cmp_vec),
    .done_o     (done_o),
    .flag_o     (mismatch_o),
    .vec_o      (result_vec_o)
  );

endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             chk_req_i,
  input logic             chk_op_i,
  input logic             input_only_i,
  input logic [WIDTH-1:0] dir_out_i,
  input logic [WIDTH-1:0] cmp_vec,
  input logic             done_o,
  input logic             mismatch_o,
  input logic [WIDTH-1:0] result_vec_o
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!done_o && !mismatch_o && result_vec_o == '0)); // R8
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst || !armed) chk_req_i |=> done_o); // R7
  AST_DONE_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst || !armed) !chk_req_i |=> !done_o); // R7
  AST_FLAG_SAMPLES_CMP: assert property (@(posedge clk) disable iff (rst || !armed) chk_req_i |=> (mismatch_o == $past(|cmp_vec))); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed) !chk_req_i |=> $stable(mismatch_o)); // R5
  AST_VEC_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed) !(chk_req_i && chk_op_i) |=> $stable(result_vec_o)); // R6
  AST_FLAG_AGREES_VEC: assert property (@(posedge clk) disable iff (rst || !armed) (chk_req_i && chk_op_i) |=> (mismatch_o == |result_vec_o)); // R5
  AST_INPUT_ONLY_CLEAN: assert property (@(posedge clk) disable iff (rst || !armed) (chk_req_i && chk_op_i && input_only_i) |=> (result_vec_o == '0)); // R4
  AST_INPUT_PIN_CLEAN: assert property (@(posedge clk) disable iff (rst || !armed) (chk_req_i && chk_op_i) |=> ((result_vec_o & ~$past(dir_out_i)) == '0)); // R3

endmodule

bind port_level_checker plc_checker #(.WIDTH(WIDTH)) u_plc_checker (
  .clk          (clk),
  .rst          (rst),
  .chk_req_i    (chk_req_i),
  .chk_op_i     (chk_op_i),
  .input_only_i (input_only_i),
  .dir_out_i    (dir_out_i),
  .cmp_vec      (cmp_vec),
  .done_o       (done_o),
  .mismatch_o   (mismatch_o),
  .result_vec_o (result_vec_o)
);

// File: tb/test_port_level_checker.sv
module test_port_level_checker;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pin = '0, latch = '0, ctrl = '0, dir = '0, src = '0;
  logic         in_only = 1'b0, req = 1'b0, op = 1'b0;
  logic         done, flag;
  logic [W-1:0] vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_level_checker i_port_level_checker (
    .clk(clk), .rst(rst), .pin_level_i(pin), .latch_i(latch), .ctrl_out_i(ctrl),
    .dir_out_i(dir), .src_ctrl_i(src), .input_only_i(in_only),
    .chk_req_i(req), .chk_op_i(op), .done_o(done), .mismatch_o(flag), .result_vec_o(vec)
  );

  // Reference model written bit by bit from the requirements.
  function automatic logic [W-1:0] ref_vec(input logic [W-1:0] p, l, c, d, s, input logic io);
    logic [W-1:0] r;
    r = '0;
    for (int b = 0; b < W; b++) begin
      if (io || !d[b]) r[b] = 1'b0;
      else if (s[b])   r[b] = p[b] != c[b];
      else             r[b] = p[b] != l[b];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Pulse a request; on return the results are visible (sampled after the edge).
  task automatic pulse(input logic o);
    @(negedge clk); req = 1'b1; op = o;
    @(negedge clk); req = 1'b0; op = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] exp_v, held_v;
    logic         held_f;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 vec", vec, 0); check("R8 flag", flag, 0); check("R8 done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 idle done", done, 0);

    // R1/R2/R6/R7: sweep all pin patterns, mixed modes and directions
    latch = 8'hA5; ctrl = 8'h3C; src = 8'hF0; dir = 8'hCF; in_only = 1'b0;
    for (int i = 0; i < 256; i++) begin
      pin = i[W-1:0];
      settle();
      pulse(1'b1);
      exp_v = ref_vec(pin, latch, ctrl, dir, src, in_only);
      check("R1 R2 vec", vec, exp_v);
      check("R5 flag", flag, |exp_v);
      check("R7 done", done, 1);
      @(negedge clk);
      check("R7 done drop", done, 0);
    end

    // R2: swap source selects across every pin
    dir = 8'hFF;
    for (int s = 0; s < 256; s += 17) begin
      src = s[W-1:0]; pin = 8'h5A ^ s[W-1:0];
      settle(); pulse(1'b1);
      check("R2 src sweep", vec, ref_vec(pin, latch, ctrl, dir, src, in_only));
    end

    // R3: all pins input, mismatching levels everywhere
    dir = 8'h00; src = 8'h0F; pin = ~latch;
    settle(); pulse(1'b1);
    check("R3 vec", vec, 0); check("R3 flag", flag, 0);
    for (int b = 0; b < W; b++) begin
      dir = 8'hFF & ~(8'h01 << b);
      settle(); pulse(1'b1);
      check("R3 single input pin", vec, ref_vec(pin, latch, ctrl, dir, src, 1'b0));
    end

    // R4: input-only strap masks everything
    dir = 8'hFF; src = 8'h00; pin = ~latch; in_only = 1'b1;
    settle(); pulse(1'b1);
    check("R4 vec", vec, 0); check("R4 flag", flag, 0);
    in_only = 1'b0;
    settle(); pulse(1'b1);
    check("R4 off vec", vec, 8'hFF);

    // R6: flag-only leaves vector, flag still updates
    held_v = vec;
    pin = latch ^ 8'h00;
    settle(); pulse(1'b0);
    check("R6 vec kept", vec, held_v);
    check("R5 flag-only update", flag, 0);
    pin = latch ^ 8'h10;
    settle(); pulse(1'b0);
    check("R6 vec kept 2", vec, held_v);
    check("R5 flag-only set", flag, 1);

    // R5: flag holds with no request while pins change
    held_f = flag;
    pin = latch;
    repeat (5) @(negedge clk);
    check("R5 flag hold", flag, held_f);
    check("R6 vec hold", vec, held_v);

    // R9: synchronizer latency
    pin = latch; settle(); pulse(1'b1);
    check("R9 baseline", vec, 0);
    @(negedge clk); pin = latch ^ 8'h81; req = 1'b1; op = 1'b1;
    @(negedge clk);
    check("R9 edge1 old", vec, 0);
    @(negedge clk);
    check("R9 edge2 old", vec, 0);
    @(negedge clk); req = 1'b0;
    check("R9 edge3 new", vec, 8'h81);
    check("R7 back-to-back done", done, 1);

    // R8: reset mid-operation clears results
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 vec again", vec, 0); check("R8 flag again", flag, 0);

    finish_run();
  end

endmodule